// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

The bridge lets a host reach a wide internal register space (16-bit addresses) through three words on a small register bus: an address port, a data port and a control port. The host first loads the internal address, then moves data through the data port. Writes through the data port go straight to the internal register at the loaded address. Reads are pipelined. Each data-port read starts an internal fetch and returns the value that the previous fetch captured. A host therefore reads the data port twice and keeps the second result.

A guard bit in the control port makes the bridge stricter. When the bit is set, the address must have been written twice with the same value before a data access. Otherwise the data access is answered with an error and the internal space is left untouched. On the internal side, the bridge drives a one-cycle read or write strobe with an address. The addressed register returns its read data on the cycle after the read strobe.

Top module: `idx_reg_bridge`

## Requirements
- R1: Offsets are decoded as follows: 0x0 is the address port, 0x4 the data port and 0x8 the control port. Any other offset, including one with its low two bits non-zero, reads as zero, ignores writes and never reports an error.
- R2: A write to the address port keeps only bits 15:0 as the internal address. A read of the address port returns that address zero-extended.
- R3: With access allowed, one write to the data port produces exactly one internal write strobe. The strobe carries the latched address and the written data.
- R4: With access allowed, a data-port read returns the value captured by the previous internal read (zero after reset) and launches one internal read strobe at the latched address. The second consecutive read therefore returns the fresh value.
- R5: After an internal read is launched, the bus ready signal stays low for exactly two cycles while the read data is captured.
- R6: Bit 15 of the control port is the guard enable and reads back as written. All other control bits read as zero.
- R7: With the guard set, a data access is rejected with rsp_err high, read data zero, no internal strobe and the capture register unchanged. This happens when the last two address-port writes differ, or when fewer than two address writes have occurred since reset.
- R8: With the guard clear, a mismatched address pair does not block access. The data access uses the most recently written address.
- R9: After reset the address, control and capture registers are zero, ready is high, and no response or strobe is active.
- R10: Each accepted request produces exactly one response, with rsp_valid high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFF_W | Byte offset of the port |
| req_wdata | input | BUS_W | Host write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | BUS_W | Read data of the response |
| rsp_err | output | 1 | Access rejected by the guard |
| int_wr | output | 1 | Internal write strobe |
| int_rd | output | 1 | Internal read strobe |
| int_addr | output | ADDR_W | Internal register address |
| int_wdata | output | BUS_W | Internal write data |
| int_rdata | input | BUS_W | Internal read data, valid one cycle after int_rd |

## Verification
The bench builds the bridge with its default parameters: a 16-bit internal address, a 32-bit data path and a 4-bit offset. With these values, the truncation of a 17-bit address value and the unmapped fourth word at offset 0xC are within reach. A behavioural model tracks the last two address writes, the guard bit and the captured value. It predicts every response and the strobe counts from these alone. It also checks that ready stays low for two cycles after each read launch, and that a rejected read leaves the captured value unchanged for the next allowed read.

// File: rtl/idx_bridge_pkg.sv
// Package: shared port selector type and control-bit position for the
// indirect register bridge. Assumes a 32-bit host bus.
package idx_bridge_pkg;
    localparam int BUS_W        = 32;
    localparam int GUARD_BIT    = 15;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_t;
endpackage

// File: rtl/idx_addr_latch.sv
// Address latch: holds the latest internal address written by the host and
// the one written before it, and reports whether the last two agree.
// Assumes load is a single-cycle pulse per accepted address-port write.
module idx_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              pair_ok
);
    logic [ADDR_W-1:0] prev_addr;
    logic [1:0]        wr_cnt;

    // Shift the new address in and count writes, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            prev_addr <= '0;
            wr_cnt    <= '0;
        end else if (load) begin
            prev_addr <= cur_addr;
            cur_addr  <= din;
            if (wr_cnt != 2'd2) wr_cnt <= wr_cnt + 2'd1;
        end
    end

    // The pair is valid once two writes have landed and they match.
    always_comb pair_ok = (wr_cnt == 2'd2) && (prev_addr == cur_addr);

    assert_latch_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_addr == $past(din));
endmodule

// File: rtl/idx_access_engine.sv
// Access engine: issues one-cycle internal read/write strobes and captures
// read data one cycle after the read strobe. Busy covers the strobe cycle
// and the capture cycle so that a following read sees the fresh value.
// Assumes go_rd and go_wr are never high together and only when !busy.
module idx_access_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_rd,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              int_rd,
    output logic              int_wr,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    output logic [DATA_W-1:0] hold,
    output logic              busy
);
    logic cap_en;

    // Register the strobes and their address/data for the internal side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_rd    <= 1'b0;
            int_wr    <= 1'b0;
            int_addr  <= '0;
            int_wdata <= '0;
        end else begin
            int_rd <= go_rd;
            int_wr <= go_wr;
            if (go_rd || go_wr) int_addr <= addr;
            if (go_wr) int_wdata <= wdata;
        end
    end

    // Capture the read data presented the cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en <= 1'b0;
            hold   <= '0;
        end else begin
            cap_en <= int_rd;
            if (cap_en) hold <= int_rdata;
        end
    end

    // Block new requests while a fetch is in flight.
    always_comb busy = int_rd || cap_en;

    assert_rd_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd |=> !int_rd);
    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_rd, int_wr}));
endmodule

// File: rtl/idx_reg_bridge.sv
// Indirect register bridge top: decodes the three host ports, holds the
// guard bit, gates data accesses on the address-pair check and forms a
// registered response one cycle after each accepted request.
// Assumes the host holds a request until it sees req_ready high.
module idx_reg_bridge
    import idx_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              rsp_err,
    output logic              int_wr,
    output logic              int_rd,
    output logic [ADDR_W-1:0] int_addr,
    output logic [BUS_W-1:0]  int_wdata,
    input  logic [BUS_W-1:0]  int_rdata
);
    localparam int WORD_W = OFF_W - 2;

    port_sel_t         sel;
    logic              accept;
    logic              guard_en;
    logic              blocked;
    logic              pair_ok;
    logic              busy;
    logic              go_rd;
    logic              go_wr;
    logic              addr_load;
    logic [ADDR_W-1:0] cur_addr;
    logic [BUS_W-1:0]  hold;
    logic [BUS_W-1:0]  rd_mux;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[BUS_W-1:ADDR_W];

    // Decode the byte offset into a port selector; misaligned is unmapped.
    always_comb begin
        sel = SEL_NONE;
        if (req_offset[1:0] == 2'b00) begin
            case (req_offset[OFF_W-1:2])
                WORD_W'(0): sel = SEL_ADDR;
                WORD_W'(1): sel = SEL_DATA;
                WORD_W'(2): sel = SEL_CTRL;
                default:    sel = SEL_NONE;
            endcase
        end
    end

    // Qualify the request and derive the per-port actions.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        blocked   = guard_en && !pair_ok;
        addr_load = accept && req_write && (sel == SEL_ADDR);
        go_wr     = accept && req_write && (sel == SEL_DATA) && !blocked;
        go_rd     = accept && !req_write && (sel == SEL_DATA) && !blocked;
    end

    // Guard enable bit of the control port.
    always_ff @(posedge clk) begin
        if (!rst_n) guard_en <= 1'b0;
        else if (accept && req_write && sel == SEL_CTRL)
            guard_en <= req_wdata[GUARD_BIT];
    end

    // Select the read value for the addressed port.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_ADDR: rd_mux = BUS_W'(cur_addr);
            SEL_DATA: rd_mux = blocked ? '0 : hold;
            SEL_CTRL: rd_mux = BUS_W'(guard_en) << GUARD_BIT;
            default:  rd_mux = '0;
        endcase
    end

    // Register the response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_err   <= accept && (sel == SEL_DATA) && blocked;
            rsp_rdata <= (accept && !req_write) ? rd_mux : '0;
        end
    end

    idx_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .din      (req_wdata[ADDR_W-1:0]),
        .cur_addr (cur_addr),
        .pair_ok  (pair_ok)
    );

    idx_access_engine #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_rd     (go_rd),
        .go_wr     (go_wr),
        .addr      (cur_addr),
        .wdata     (req_wdata),
        .int_rdata (int_rdata),
        .int_rd    (int_rd),
        .int_wr    (int_wr),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .hold      (hold),
        .busy      (busy)
    );

    assert_no_strobe_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!int_wr && !int_rd));
    assert_ready_low_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd |=> !req_ready);
    assert_response_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/idx_reg_bridge_test.sv
`timescale 1ns/1ps
module idx_reg_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        int_wr, int_rd;
    logic [15:0] int_addr;
    logic [31:0] int_wdata;
    logic [31:0] int_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int wr_seen = 0, rd_seen = 0;
    int wr_exp = 0, rd_exp = 0;

    // Behavioural reference state.
    logic [31:0] smem [int];
    int          m_cur = 0, m_prev = 0, m_cnt = 0;
    bit          m_en = 0;
    logic [31:0] m_hold = '0;

    always #10 clk = ~clk;

    idx_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .int_wr(int_wr), .int_rd(int_rd), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata)
    );

    function automatic logic [31:0] sval(int a);
        return smem.exists(a) ? smem[a] : {16'hA5A5, a[15:0]};
    endfunction

    // Internal register space and strobe monitor.
    always @(posedge clk) begin
        if (int_wr) begin smem[int'(int_addr)] = int_wdata; wr_seen++; end
        if (int_rd) begin int_rdata <= sval(int'(int_addr)); rd_seen++; end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host access checked against the reference model.
    task automatic acc(bit w, logic [3:0] off, logic [31:0] d, string req);
        bit ok_pair, blk, is_rd_launch;
        logic [31:0] exp_d;
        bit exp_e;
        int guard;
        ok_pair = (m_cnt == 2) && (m_prev == m_cur);
        blk = m_en && !ok_pair;
        exp_d = '0; exp_e = 0; is_rd_launch = 0;
        guard = 0;
        while (req_ready !== 1'b1 && guard < 10) begin @(negedge clk); guard++; end
        req_valid = 1; req_write = w; req_offset = off; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        case (off)
            4'h0: if (w) begin m_prev = m_cur; m_cur = int'(d[15:0]);
                      if (m_cnt < 2) m_cnt++; end
                  else exp_d = {16'h0, m_cur[15:0]};
            4'h4: if (blk) exp_e = 1;
                  else if (w) wr_exp++;
                  else begin exp_d = m_hold; m_hold = sval(m_cur);
                      rd_exp++; is_rd_launch = 1; end
            4'h8: if (w) m_en = d[15]; else exp_d = {16'h0, m_en, 15'h0};
            default: ;
        endcase
        check({req, " R10 rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
        check({req, " rdata"}, rsp_rdata, exp_d);
        check({req, " err"}, {31'h0, rsp_err}, {31'h0, exp_e});
        if (is_rd_launch) begin
            check("R5 ready low cycle 1", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            check("R5 ready low cycle 2", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            check("R5 ready back high", {31'h0, req_ready}, 32'h1);
        end
    endtask

    task automatic strobes(string req);
        @(negedge clk); @(negedge clk);
        check({req, " write strobes"}, wr_seen, wr_exp);
        check({req, " read strobes"}, rd_seen, rd_exp);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 ready", {31'h0, req_ready}, 32'h1);
        check("R9 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R9 strobes", {30'h0, int_wr, int_rd}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        acc(0, 4'h8, 0, "R9 ctrl read");
        acc(0, 4'h0, 0, "R9 addr read");
        acc(0, 4'h4, 0, "R9 hold zero");
        strobes("R9");
        // R2 truncation, R3 write
        acc(1, 4'h0, 32'h0001_0012, "R2 addr wr1");
        acc(1, 4'h0, 32'h0001_0012, "R2 addr wr2");
        acc(0, 4'h0, 0, "R2 addr readback");
        acc(1, 4'h4, 32'hCAFE_0001, "R3 data write");
        strobes("R3");
        check("R3 stored value", smem[32'h12], 32'hCAFE_0001);
        // R4 double read
        acc(0, 4'h4, 0, "R4 first read");
        acc(0, 4'h4, 0, "R4 second read");
        strobes("R4");
        // R1 unmapped and misaligned, R6 control
        acc(1, 4'hC, 32'hFFFF_FFFF, "R1 unmapped write");
        acc(0, 4'hC, 0, "R1 unmapped read");
        acc(0, 4'h5, 0, "R1 misaligned read");
        acc(1, 4'h8, 32'hFFFF_FFFF, "R6 ctrl set");
        acc(0, 4'h8, 0, "R6 ctrl read");
        acc(0, 4'h0, 0, "R1 addr unaffected");
        // R7 guard rejects mismatched pair
        acc(1, 4'h0, 32'h20, "R7 addr a");
        acc(1, 4'h0, 32'h21, "R7 addr b");
        acc(1, 4'h4, 32'h5555_AAAA, "R7 blocked write");
        acc(0, 4'h4, 0, "R7 blocked read");
        strobes("R7");
        acc(1, 4'h0, 32'h21, "R7 pair fixed");
        acc(0, 4'h4, 0, "R7 hold kept");
        acc(0, 4'h4, 0, "R7 fresh read");
        strobes("R7 after");
        // R8 guard clear lets mismatch through
        acc(1, 4'h8, 32'h0, "R8 guard off");
        acc(1, 4'h0, 32'h30, "R8 addr a");
        acc(1, 4'h0, 32'h31, "R8 addr b");
        acc(1, 4'h4, 32'h0000_1234, "R8 write");
        acc(0, 4'h4, 0, "R8 read 1");
        acc(0, 4'h4, 0, "R8 read 2");
        strobes("R8");
        check("R8 target address", smem[32'h31], 32'h0000_1234);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule